// File: doc/BRIEF.md
# GPIO Event Core

This block is the bus-independent heart of a small general-purpose I/O port. Raw pad inputs are brought into the system clock domain through a per-pin flop chain, and the synchronized value is handed to the bus side, where a data-in register would read it. From that same synchronized copy the block derives four event flags per pin: level high, level low, rising edge and falling edge. A later stage can latch, mask or clear these flags.

In the output direction the block passes the output data and direction bits written by the bus straight to the pad interface. A direction bit of 1 turns the pin into an output. Bus decoding, register storage and interrupt latching belong to the surrounding wrapper and are not part of this block.

Top module: `gpio_event_core`

## Requirements
- R1: A reset, sampled high on a rising clock edge, clears every synchronizer and history flop. In the following cycle `bus_in` is 0, `flag_hi` is 0, `flag_lo` is all ones, and `flag_rise` and `flag_fall` are 0.
- R2: Outside reset, `bus_in` equals the value that `pin_in` had SYNC_STAGES clock edges earlier. SYNC_STAGES defaults to 2.
- R3: `pad_out` equals `bus_out` and `pad_oe` equals `bus_dir` in the same cycle, with no register between them. In `bus_dir`, bit n = 1 makes pin n an output and bit n = 0 makes it an input.
- R4: `flag_hi[n]` is 1 exactly while `bus_in[n]` is 1, and `flag_lo[n]` is 1 exactly while `bus_in[n]` is 0.
- R5: `flag_rise[n]` is 1 for exactly one cycle, in the first cycle where `bus_in[n]` reads 1 after reading 0 in the cycle before.
- R6: `flag_fall[n]` is 1 for exactly one cycle, in the first cycle where `bus_in[n]` reads 0 after reading 1 in the cycle before.
- R7: No edge flag is raised in the first cycle after reset. A pin held high through reset raises one rising-edge flag, in the cycle when its synchronized value first reads 1.
- R8: A pin pulse one clock cycle wide gives a rising-edge flag followed, in the very next cycle, by a falling-edge flag on that pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | 8 | Raw asynchronous pad inputs |
| pad_out | output | 8 | Output values driven to the pads |
| pad_oe | output | 8 | Per-pin output enable, 1 = drive |
| bus_in | output | 8 | Synchronized pin values for the data-in register |
| bus_out | input | 8 | Output data supplied by the bus side |
| bus_dir | input | 8 | Direction bits supplied by the bus side, 1 = output |
| flag_hi | output | 8 | Per-pin level-high flag |
| flag_lo | output | 8 | Per-pin level-low flag |
| flag_rise | output | 8 | Per-pin rising-edge pulse |
| flag_fall | output | 8 | Per-pin falling-edge pulse |

## Verification
Two functions can fire in the same cycle: a rising edge on one pin and a falling edge on another. On a single pin, a rising edge and a falling edge can also land in back-to-back cycles. Random input bytes change many pins in each cycle, so mixed rise and fall vectors occur often. A directed one-cycle pulse produces the back-to-back case on a single pin. The bench keeps its own model of the delay line and history and compares all four flag vectors in every cycle, so a flag that leaks onto a neighbouring pin, or that persists for an extra cycle, shows up as a mismatch.

// File: rtl/gpio_core_pkg.sv
package gpio_core_pkg;
  localparam int unsigned DEF_PINS        = 8;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    EVT_NONE = 2'b00,
    EVT_RISE = 2'b01,
    EVT_FALL = 2'b10
  } edge_kind_e;

  function automatic edge_kind_e classify(input logic now_v, input logic old_v);
    if (now_v && !old_v)      return EVT_RISE;
    else if (!now_v && old_v) return EVT_FALL;
    else                      return EVT_NONE;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned PINS   = gpio_core_pkg::DEF_PINS,
  parameter int unsigned STAGES = gpio_core_pkg::DEF_SYNC_STAGES
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] raw_i,
  output logic [PINS-1:0] sync_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [PINS-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= raw_i;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[k] <= '0;
      else     chain[k] <= chain[k-1];
    end
  end

  assign sync_o = chain[LAST];

  initial begin
    a_r2_depth: assert (STAGES >= 2);
  end
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_core_pkg::*;
#(
  parameter int unsigned PINS = gpio_core_pkg::DEF_PINS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] level_i,
  output logic [PINS-1:0] hi_o,
  output logic [PINS-1:0] lo_o,
  output logic [PINS-1:0] rise_o,
  output logic [PINS-1:0] fall_o
);
  logic [PINS-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst) hist_q <= '0;
    else     hist_q <= level_i;
  end

  for (genvar n = 0; n < PINS; n++) begin : g_pin
    edge_kind_e kind;
    always_comb kind = classify(level_i[n], hist_q[n]);
    assign hi_o[n]   = level_i[n];
    assign lo_o[n]   = ~level_i[n];
    assign rise_o[n] = (kind == EVT_RISE);
    assign fall_o[n] = (kind == EVT_FALL);
  end

  a_r5_rise_single: assert property (@(posedge clk) disable iff (rst)
    (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));

  a_r6_fall_single: assert property (@(posedge clk) disable iff (rst)
    (fall_o != '0) |=> ((fall_o & $past(fall_o)) == '0));

  a_r7_quiet_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> (rise_o == '0 && fall_o == '0));

  a_r8_rise_then_level: assert property (@(posedge clk) disable iff (rst)
    (rise_o != '0) |-> ((rise_o & lo_o) == '0));
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
  parameter int unsigned PINS = gpio_core_pkg::DEF_PINS
) (
  input  logic [PINS-1:0] data_i,
  input  logic [PINS-1:0] dir_i,
  output logic [PINS-1:0] pad_data_o,
  output logic [PINS-1:0] pad_en_o
);
  for (genvar n = 0; n < PINS; n++) begin : g_pad
    assign pad_data_o[n] = data_i[n];
    assign pad_en_o[n]   = dir_i[n];
  end
endmodule

// File: rtl/gpio_event_core.sv
module gpio_event_core #(
  parameter int unsigned PINS        = gpio_core_pkg::DEF_PINS,
  parameter int unsigned SYNC_STAGES = gpio_core_pkg::DEF_SYNC_STAGES
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe,
  output logic [PINS-1:0] bus_in,
  input  logic [PINS-1:0] bus_out,
  input  logic [PINS-1:0] bus_dir,
  output logic [PINS-1:0] flag_hi,
  output logic [PINS-1:0] flag_lo,
  output logic [PINS-1:0] flag_rise,
  output logic [PINS-1:0] flag_fall
);
  logic [PINS-1:0] synced;

  gpio_in_sync #(.PINS(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .raw_i  (pin_in),
    .sync_o (synced)
  );

  gpio_evt_detect #(.PINS(PINS)) u_evt (
    .clk     (clk),
    .rst     (rst),
    .level_i (synced),
    .hi_o    (flag_hi),
    .lo_o    (flag_lo),
    .rise_o  (flag_rise),
    .fall_o  (flag_fall)
  );

  gpio_pad_drive #(.PINS(PINS)) u_pad (
    .data_i     (bus_out),
    .dir_i      (bus_dir),
    .pad_data_o (pad_out),
    .pad_en_o   (pad_oe)
  );

  assign bus_in = synced;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (bus_in == '0 && flag_rise == '0 && flag_fall == '0));

  a_r4_level_tracks_bus: assert property (@(posedge clk) disable iff (rst)
    (flag_hi == bus_in) && (flag_lo == ~bus_in));
endmodule

// File: tb/gpio_event_core_tb_top.sv
module gpio_event_core_tb_top;
  localparam int S = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] pin_in = '0, bus_out = '0, bus_dir = '0;
  logic [7:0] pad_out, pad_oe, bus_in, flag_hi, flag_lo, flag_rise, flag_fall;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] pipe [S];
  logic [7:0] prev;

  always #4 clk = ~clk;

  gpio_event_core dut_i (
    .clk(clk), .rst(rst), .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .bus_in(bus_in), .bus_out(bus_out), .bus_dir(bus_dir), .flag_hi(flag_hi),
    .flag_lo(flag_lo), .flag_rise(flag_rise), .flag_fall(flag_fall)
  );

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rise();
    return pipe[S-1] & ~prev;
  endfunction
  function automatic logic [7:0] exp_fall();
    return ~pipe[S-1] & prev;
  endfunction

  task automatic model_clock(input logic [7:0] din, input logic r);
    if (r) begin
      for (int k = 0; k < S; k++) pipe[k] = '0;
      prev = '0;
    end else begin
      prev = pipe[S-1];
      for (int k = S-1; k > 0; k--) pipe[k] = pipe[k-1];
      pipe[0] = din;
    end
  endtask

  task automatic cycle(input logic [7:0] din, input logic r, input string tag);
    logic was_rst;
    pin_in  = din;
    rst     = r;
    bus_out = 8'($urandom);
    bus_dir = 8'($urandom);
    #1;
    chk(pad_out == bus_out, "R3 pad_out", pad_out, bus_out);
    chk(pad_oe == bus_dir, "R3 pad_oe", pad_oe, bus_dir);
    was_rst = r;
    @(posedge clk);
    model_clock(din, r);
    @(negedge clk);
    if (was_rst) begin
      chk(bus_in == 8'h00 && flag_hi == 8'h00 && flag_lo == 8'hFF &&
          flag_rise == 8'h00 && flag_fall == 8'h00, "R1 reset state",
          bus_in | flag_rise | flag_fall, 8'h00);
    end else begin
      chk(bus_in == pipe[S-1], {"R2 bus_in ", tag}, bus_in, pipe[S-1]);
      chk(flag_hi == pipe[S-1], {"R4 hi ", tag}, flag_hi, pipe[S-1]);
      chk(flag_lo == ~pipe[S-1], {"R4 lo ", tag}, flag_lo, ~pipe[S-1]);
      chk(flag_rise == exp_rise(), {"R5 rise ", tag}, flag_rise, exp_rise());
      chk(flag_fall == exp_fall(), {"R6 fall ", tag}, flag_fall, exp_fall());
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 8'h00, 8'h01);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    for (int k = 0; k < S; k++) pipe[k] = '0;
    prev = '0;
    @(negedge clk);
    cycle(8'h00, 1'b1, "rst");
    cycle(8'h00, 1'b1, "rst");

    // R7: pins high through reset, no edge right after release
    cycle(8'hFF, 1'b1, "R7 hold");
    cycle(8'hFF, 1'b1, "R7 hold");
    cycle(8'hFF, 1'b0, "R7 first");
    chk(flag_rise == 8'h00 && flag_fall == 8'h00, "R7 no edge first cycle", flag_rise | flag_fall, 8'h00);
    cycle(8'hFF, 1'b0, "R7 second");
    chk(flag_rise == 8'hFF, "R7 rise when sync reads 1", flag_rise, 8'hFF);
    cycle(8'hFF, 1'b0, "R7 third");
    chk(flag_rise == 8'h00, "R7 single rise", flag_rise, 8'h00);

    // R8: one-cycle pulse on pin 3
    cycle(8'h00, 1'b0, "R8 low");
    cycle(8'h00, 1'b0, "R8 low");
    cycle(8'h00, 1'b0, "R8 low");
    cycle(8'h08, 1'b0, "R8 pulse");
    cycle(8'h00, 1'b0, "R8 after");
    chk(flag_rise == 8'h08 && flag_fall == 8'h00, "R8 rise of pulse", flag_rise, 8'h08);
    cycle(8'h00, 1'b0, "R8 after");
    chk(flag_fall == 8'h08 && flag_rise == 8'h00, "R8 fall of pulse", flag_fall, 8'h08);

    // Mixed rise on some pins, fall on others in one cycle (R5, R6)
    cycle(8'hF0, 1'b0, "mix");
    cycle(8'h0F, 1'b0, "mix");
    cycle(8'h0F, 1'b0, "mix");
    chk(flag_rise == 8'h0F && flag_fall == 8'hF0, "R5 R6 mixed edges", flag_rise, 8'h0F);

    for (int i = 0; i < 3000; i++) begin
      logic r;
      r = ($urandom % 200) == 0;
      cycle(8'($urandom), r, "random");
    end
    for (int i = 0; i < 500; i++) begin
      cycle(($urandom % 4 == 0) ? 8'($urandom) : pin_in, 1'b0, "slow");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule